// File: doc/BRIEF.md
# Inverted Page-Table Address Translator

This block turns a 26-bit logical byte address into a 22-bit physical byte address. It keeps one tag slot for each of the 128 physical pages of the memory behind it. Each slot holds the logical page number now mapped onto that page, plus a valid flag. A lookup compares the incoming logical page number against every slot at once. The number of the slot that matches is the physical page number. The table therefore never runs short of descriptors. A physical page can only ever sit at one logical address, because its slot holds a single tag.

The size of the installed memory sets the page size, because that memory is always split into 128 pages. A 2-bit select chooses a page offset of 12, 13, 14 or 15 bits. The bits of the logical address above the offset form the logical page number. Software loads a slot through a one-entry-per-cycle write port. Every lookup produces a registered result one clock later: a physical address on a hit, or an abort flag on a miss.

Top module: `pgx_translator`

## Requirements
- R1: All 128 slots can be loaded and looked up. A hit in slot k places k in physical address bits [o+6:o], where o is the offset width.
- R2: Page select encoding is 0 for 4 KB, 1 for 8 KB, 2 for 16 KB and 3 for 32 KB, giving an offset width o of 12, 13, 14 or 15. The logical page number is the logical address shifted right by o, zero-extended to 14 bits. A slot matches when its stored 14-bit tag equals that number.
- R3: On a hit, physical address = (slot index << o) | (logical address bits [o-1:0]), and all bits above o+6 are 0.
- R4: A lookup that matches no valid slot raises the abort output in the result cycle, with the physical address output at 0. A hit leaves abort low.
- R5: If several valid slots match, the lowest-numbered one supplies the address and the multi-match output is high. With a single match it stays low.
- R6: A slot write (index, tag, valid) takes effect at the clock edge that samples it. A lookup sampled at that same edge sees the old contents.
- R7: Synchronous reset clears every valid flag and every result output, so all lookups miss until slots are loaded again.
- R8: A result comes out one cycle after each lookup request, one per clock. Result-valid is high exactly when a request was sampled at the previous edge. With no request, abort and multi-match stay low.
- R9: Rewriting a slot replaces its old tag, so the old logical page no longer hits that slot. Writing with the valid flag at 0 removes the slot from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | 26 | Logical byte address to translate |
| pg_size | input | 2 | Page-size select (0:4K, 1:8K, 2:16K, 3:32K) |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 7 | Physical page (slot) to write |
| wr_lpn | input | 14 | Logical page tag to store |
| wr_vld | input | 1 | Valid flag to store |
| xl_valid | output | 1 | Result valid, one cycle after lk_valid |
| xl_abort | output | 1 | Translation miss |
| xl_multi | output | 1 | More than one slot matched |
| xl_paddr | output | 22 | Physical byte address (0 on miss) |

## Verification
Each result is due exactly one cycle after its request. The bench drives a request on a falling edge, waits for the next rising edge, and samples 1 ns later, so every check reads the result of that request and nothing else. A slot write takes effect at the same edge. The bench therefore checks the lookup issued alongside a write against the old table, and checks the lookup on the following cycle against the new table. Reset takes effect on its first rising edge, and the outputs are checked right after that edge.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int LA_W    = 26;
    localparam int IDX_W   = 7;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int SZ_W    = 2;
    localparam int MIN_OFS = 12;
    localparam int MAX_OFS = MIN_OFS + (1 << SZ_W) - 1;
    localparam int LPN_W   = LA_W - MIN_OFS;
    localparam int PA_W    = IDX_W + MAX_OFS;

    typedef enum logic [SZ_W-1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic             valid;
        logic [LPN_W-1:0] lpn;
        logic [LA_W-1:0]  laddr;
        logic [4:0]       ofs_w;
    } lk_req_t;

    typedef struct packed {
        logic            valid;
        logic            abort;
        logic            multi;
        logic [PA_W-1:0] paddr;
    } xl_res_t;

    function automatic logic [4:0] ofs_width(pgsz_e sz);
        return 5'(MIN_OFS) + 5'(sz);
    endfunction

    function automatic logic [LPN_W-1:0] page_of(logic [LA_W-1:0] la, logic [4:0] ow);
        logic [LPN_W-1:0] r;
        r = '0;
        for (int b = 0; b < LPN_W; b++) begin
            for (int s = MIN_OFS; s <= MAX_OFS; s++) begin
                if (int'(ow) == s && (b + s) < LA_W)
                    r[b] = la[b + s];
            end
        end
        return r;
    endfunction

    function automatic logic [PA_W-1:0] join_pa(logic [IDX_W-1:0] idx,
                                                logic [LA_W-1:0] la,
                                                logic [4:0] ow);
        logic [PA_W-1:0] r;
        r = '0;
        for (int b = 0; b < PA_W; b++) begin
            if (b < int'(ow))
                r[b] = la[b];
            else if ((b - int'(ow)) < IDX_W)
                r[b] = idx[b - int'(ow)];
        end
        return r;
    endfunction

endpackage

// File: rtl/pgx_tag_store.sv
module pgx_tag_store
    import pgx_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int IW = IDX_W,
    parameter int TW = LPN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_lpn,
    input  logic          wr_vld,
    output logic [TW-1:0] tag_q [N],
    output logic [N-1:0]  vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst)
            tag_q[wr_idx] <= wr_lpn;
    end

    // R7: reset leaves no slot valid
    p_reset_clears_r7: assert property (@(posedge clk) rst |=> vld_q == '0);

    // R6/R9: a written slot holds the new tag and flag after the edge
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_lpn)) &&
                  (vld_q[$past(wr_idx)] == $past(wr_vld)));

endmodule

// File: rtl/pgx_match_array.sv
module pgx_match_array
    import pgx_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int TW = LPN_W
) (
    input  logic [TW-1:0] lpn,
    input  logic [TW-1:0] tag_q [N],
    input  logic [N-1:0]  vld_q,
    output logic [N-1:0]  hit_vec
);

    for (genvar g = 0; g < N; g++) begin : g_cell
        assign hit_vec[g] = vld_q[g] && (tag_q[g] == lpn);
    end

endmodule

// File: rtl/pgx_prio_enc.sv
module pgx_prio_enc
    import pgx_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hit_vec,
    output logic          any_hit,
    output logic          multi,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i])
                idx = IW'(i);
        end
    end

    always_comb begin
        logic seen;
        seen  = 1'b0;
        multi = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                if (seen)
                    multi = 1'b1;
                seen = 1'b1;
            end
        end
        any_hit = seen;
    end

    // R5: the chosen slot matches and no lower slot does
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> hit_vec[idx] && ((hit_vec & ((N'(1) << idx) - N'(1))) == '0));

    // R5: the multi flag agrees with the match count
    p_multi_count_r5: assert property (@(posedge clk) disable iff (rst)
        multi == ($countones(hit_vec) > 1));

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [LA_W-1:0]    lk_laddr,
    input  logic [SZ_W-1:0]    pg_size,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LPN_W-1:0]   wr_lpn,
    input  logic               wr_vld,
    output logic               xl_valid,
    output logic               xl_abort,
    output logic               xl_multi,
    output logic [PA_W-1:0]    xl_paddr
);

    lk_req_t            req;
    xl_res_t            res_d, res_q;
    logic [LPN_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               multi;
    logic [IDX_W-1:0]   hit_idx;

    always_comb begin
        req.valid = lk_valid;
        req.laddr = lk_laddr;
        req.ofs_w = ofs_width(pgsz_e'(pg_size));
        req.lpn   = page_of(lk_laddr, req.ofs_w);
    end

    pgx_tag_store #(.N(ENTRIES), .IW(IDX_W), .TW(LPN_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_lpn (wr_lpn),
        .wr_vld (wr_vld),
        .tag_q  (tag_q),
        .vld_q  (vld_q)
    );

    pgx_match_array #(.N(ENTRIES), .TW(LPN_W)) u_match (
        .lpn     (req.lpn),
        .tag_q   (tag_q),
        .vld_q   (vld_q),
        .hit_vec (hit_vec)
    );

    pgx_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .multi   (multi),
        .idx     (hit_idx)
    );

    always_comb begin
        res_d.valid = req.valid;
        res_d.abort = req.valid && !any_hit;
        res_d.multi = req.valid && multi;
        res_d.paddr = (req.valid && any_hit) ? join_pa(hit_idx, req.laddr, req.ofs_w) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign xl_valid = res_q.valid;
    assign xl_abort = res_q.abort;
    assign xl_multi = res_q.multi;
    assign xl_paddr = res_q.paddr;

    // R8: one result per request, one cycle later
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> xl_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !xl_valid && !xl_abort && !xl_multi);

    // R4: a request with no matching slot aborts with a zero address
    p_miss_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit_vec == '0) |=> xl_abort && xl_paddr == '0);
    p_hit_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit_vec != '0) |=> !xl_abort);

    // R3: the page field of the address carries the chosen slot
    p_paddr_page_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && any_hit) |=>
            (xl_paddr >> $past(req.ofs_w)) == PA_W'($past(hit_idx)));

    // R5: multi-match is only reported on a hit
    p_multi_hit_r5: assert property (@(posedge clk) disable iff (rst)
        xl_multi |-> xl_valid && !xl_abort);

endmodule

// File: tb/test_pgx_translator.sv
`timescale 1ns/1ps
module test_pgx_translator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [25:0] lk_laddr = '0;
    logic [1:0]  pg_size = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [13:0] wr_lpn = '0;
    logic        wr_vld = 1'b0;
    logic        xl_valid, xl_abort, xl_multi;
    logic [21:0] xl_paddr;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pgx_translator i_pgx_translator (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_laddr(lk_laddr),
        .pg_size(pg_size), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lpn(wr_lpn),
        .wr_vld(wr_vld), .xl_valid(xl_valid), .xl_abort(xl_abort),
        .xl_multi(xl_multi), .xl_paddr(xl_paddr)
    );

    typedef struct packed {
        logic        we;
        logic [6:0]  widx;
        logic [13:0] wlpn;
        logic        wv;
        logic        lv;
        logic [25:0] la;
        logic [1:0]  sz;
        logic        ev;
        logic        ea;
        logic        em;
        logic [21:0] epa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'd5,   14'h0003, 1'b1, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b1, 1'b0, 22'h0,     4'd6}, // R6 old view
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b0, 1'b0, 22'h05123, 4'd3}, // R3
        '{1'b1, 7'd127, 14'h3FFF, 1'b1, 1'b1, 26'h3FFFFFF, 2'd0, 1'b1, 1'b1, 1'b0, 22'h0,     4'd6}, // R6
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h3FFFFFF, 2'd0, 1'b1, 1'b0, 1'b0, 22'h7FFFF, 4'd1}, // R1 top slot
        '{1'b1, 7'd0,   14'h0002, 1'b1, 1'b0, 26'h0000000, 2'd0, 1'b0, 1'b0, 1'b0, 22'h0,     4'd8}, // R8 idle
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0005ABC, 2'd1, 1'b1, 1'b0, 1'b0, 22'h01ABC, 4'd2}, // R2 8K
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0002FFF, 2'd0, 1'b1, 1'b0, 1'b0, 22'h00FFF, 4'd2}, // R2 4K
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0017ABC, 2'd3, 1'b1, 1'b0, 1'b0, 22'h07ABC, 4'd2}, // R2 32K
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h000E345, 2'd2, 1'b1, 1'b0, 1'b0, 22'h16345, 4'd3}, // R3 16K
        '{1'b1, 7'd9,   14'h0003, 1'b1, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b0, 1'b0, 22'h05123, 4'd6}, // R6
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b0, 1'b1, 22'h05123, 4'd5}, // R5
        '{1'b1, 7'd5,   14'h0040, 1'b1, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b0, 1'b1, 22'h05123, 4'd6}, // R6
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b0, 1'b0, 22'h09123, 4'd9}, // R9 remap
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0040007, 2'd0, 1'b1, 1'b0, 1'b0, 22'h05007, 4'd9}, // R9
        '{1'b1, 7'd9,   14'h0003, 1'b0, 1'b0, 26'h0000000, 2'd0, 1'b0, 1'b0, 1'b0, 22'h0,     4'd8}, // R8
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h0003123, 2'd0, 1'b1, 1'b1, 1'b0, 22'h0,     4'd9}, // R9 invalidate
        '{1'b0, 7'd0,   14'h0000, 1'b0, 1'b1, 26'h3FFFFFF, 2'd3, 1'b1, 1'b1, 1'b0, 22'h0,     4'd4}  // R4 miss
    };

    task automatic chk(input string tag, input logic [21:0] act, input logic [21:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic [6:0] widx, input logic [13:0] wlpn,
                         input logic wv, input logic lv, input logic [25:0] la,
                         input logic [1:0] sz);
        @(negedge clk);
        wr_en = we; wr_idx = widx; wr_lpn = wlpn; wr_vld = wv;
        lk_valid = lv; lk_laddr = la; pg_size = sz;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_out(input string tag, input logic ev, input logic ea,
                           input logic em, input logic [21:0] epa);
        chk({tag, " valid"}, 22'(xl_valid), 22'(ev));
        chk({tag, " abort"}, 22'(xl_abort), 22'(ea));
        chk({tag, " multi"}, 22'(xl_multi), 22'(em));
        chk({tag, " paddr"}, xl_paddr, epa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_out("R7 reset state", 1'b0, 1'b0, 1'b0, 22'h0);
        @(negedge clk);
        rst = 1'b0;

        // R7: nothing hits before any slot is loaded
        cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b1, 26'h0000000, 2'd0);
        chk_out("R7 empty table", 1'b1, 1'b1, 1'b0, 22'h0);

        for (int v = 0; v < NV; v++) begin
            cycle(VECS[v].we, VECS[v].widx, VECS[v].wlpn, VECS[v].wv,
                  VECS[v].lv, VECS[v].la, VECS[v].sz);
            chk_out($sformatf("R%0d vec%0d", VECS[v].rq, v),
                    VECS[v].ev, VECS[v].ea, VECS[v].em, VECS[v].epa);
        end

        // R1: load every slot with a distinct tag, then find each one
        for (int i = 0; i < 128; i++)
            cycle(1'b1, 7'(i), 14'(16'h100 + i), 1'b1, 1'b0, 26'h0, 2'd0);
        for (int i = 0; i < 128; i++) begin
            logic [25:0] la;
            la = (26'(16'h100 + i) << 12) | 26'((i * 37) & 12'hFFF);
            cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b1, la, 2'd0);
            chk_out($sformatf("R1 slot %0d", i), 1'b1, 1'b0, 1'b0,
                    (22'(i) << 12) | 22'((i * 37) & 12'hFFF));
        end

        // R7: reset with a request pending wipes results and the table
        @(negedge clk);
        rst = 1'b1; lk_valid = 1'b1; lk_laddr = 26'h0100000; wr_en = 1'b0;
        @(posedge clk);
        #1;
        chk_out("R7 reset mid-run", 1'b0, 1'b0, 1'b0, 22'h0);
        @(negedge clk);
        rst = 1'b0;
        cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b1, 26'h0100000, 2'd0);
        chk_out("R7 cleared slot", 1'b1, 1'b1, 1'b0, 22'h0);

        // R8: back-to-back requests, then idle
        cycle(1'b1, 7'd3, 14'h0007, 1'b1, 1'b0, 26'h0, 2'd0);
        cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b1, 26'h0007001, 2'd0);
        chk_out("R8 b2b first", 1'b1, 1'b0, 1'b0, 22'h03001);
        cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b1, 26'h0008001, 2'd0);
        chk_out("R8 b2b second", 1'b1, 1'b1, 1'b0, 22'h0);
        cycle(1'b0, 7'd0, 14'h0, 1'b0, 1'b0, 26'h0007001, 2'd0);
        chk_out("R8 idle", 1'b0, 1'b0, 1'b0, 22'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule